// File: doc/BRIEF.md
# Fractional-N Feedback Divider Controller

This block divides a fast input clock by an integer that changes from one output period to the next. Over time the average division ratio equals INT + FRAC/MOD. A third-order noise-shaping sequencer picks each period's integer. It is made of three modulo-MOD accumulators in cascade, and their carries are combined into a small signed offset. That offset is added to INT to give the length of the next period. The block emits one single-cycle pulse per completed period, which a phase comparator can use. It also exposes the divide value of the period in progress.

The modulus may be any value from 2 to 4095, and FRAC runs from 0 to MOD-1. INT, FRAC and MOD are sampled only when a new period is loaded, so reprogramming never distorts a period already under way. The accumulators advance once per output period. When FRAC is zero the sequencer is cleared and the block acts as a plain integer divider.

Top module: `frac_n_div`

## Requirements
- R1: While rst_ni is low, pulse_o is 0 and div_o is 0.
- R2: The number of clk_i cycles between two consecutive pulse_o cycles equals the div_o value shown during the cycle of the first of those two pulses.
- R3: With frac_i = 0 at a period load, that period's div_o equals int_i, and the periods that follow stay exactly int_i long.
- R4: Every loaded div_o lies between int_i - 3 and int_i + 4, where int_i is the value sampled at that load.
- R5: With constant settings, any 6*MOD consecutive periods, taken once at least four periods have passed since a load with frac_i = 0, total exactly 6*(INT*MOD + FRAC) input cycles.
- R6: A change of int_i, frac_i or mod_i in the middle of a period leaves that period's length and div_o unchanged, and takes effect from the next period.
- R7: pulse_o is high for exactly one clk_i cycle per completed period, and it rises in the cycle that starts the next period.
- R8: Divide values from 28 up to 515 are counted without wrapping, which covers INT = 31 and INT = 511 with a nonzero fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Divider input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| int_i | input | 9 | Integer part of the ratio (31..511) |
| frac_i | input | 12 | Fraction numerator (0..MOD-1) |
| mod_i | input | 12 | Fractional modulus (2..4095) |
| pulse_o | output | 1 | One-cycle pulse per completed division period |
| div_o | output | 10 | Divide value of the period in progress |

## Verification
The integer pattern (FRAC = 0) isolates the counter and the load path from the sequencer, so a wrong period length shows up as a plain miscount. Fraction patterns with MOD = 2, 5, 13 and 3 run a full 6*MOD-period window and compare the summed period lengths with the exact rational total. This separates a correct noise shaper from one that only gets the first-order carry right, or one whose accumulators wrap at the wrong point. Runs at INT = 31 and INT = 511 exercise the lowest and highest divide values. A long MOD = 4095 run checks the offset bounds with a modulus that is not a power of two. A mid-period change of INT shows whether settings are taken only at the boundary.

// File: rtl/frac_n_div_pkg.sv
package frac_n_div_pkg;
  localparam int unsigned STAGES  = 3;
  localparam int unsigned OFS_W   = 4;
  localparam int          OFS_MIN = -3;
  localparam int          OFS_MAX = 4;
  localparam int          INT_MIN = 31;

  typedef logic signed [OFS_W-1:0] ofs_t;

  // delayed carries needed by the differentiators
  typedef struct packed {
    logic c2_p;
    logic c3_p;
    logic c3_pp;
  } hist_t;
endpackage

// File: rtl/frac_n_div_acc.sv
module frac_n_div_acc #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         clr_i,
  input  logic [W-1:0] add_i,
  input  logic [W-1:0] mod_i,
  output logic [W-1:0] nxt_o,
  output logic         cy_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;
  logic [W:0]   red;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, add_i};
    red   = sum - {1'b0, mod_i};
    cy_o  = (sum >= {1'b0, mod_i});
    nxt_o = cy_o ? red[W-1:0] : sum[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (step_i) acc_q <= nxt_o;
  end
endmodule

// File: rtl/frac_n_div_mash.sv
module frac_n_div_mash
  import frac_n_div_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         clr_i,
  input  logic [W-1:0] frac_i,
  input  logic [W-1:0] mod_i,
  output ofs_t         ofs_o
);
  logic [STAGES-1:0][W-1:0] add_w;
  logic [STAGES-1:0][W-1:0] nxt_w;
  logic [STAGES-1:0]        cy_w;
  hist_t                    h_q;
  ofs_t                     raw;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign add_w[g] = frac_i;
    end else begin : g_chain
      // each stage integrates the new residue of the stage before it
      assign add_w[g] = nxt_w[g-1];
    end
    frac_n_div_acc #(.W(W)) u_acc (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .step_i(step_i),
      .clr_i (clr_i),
      .add_i (add_w[g]),
      .mod_i (mod_i),
      .nxt_o (nxt_w[g]),
      .cy_o  (cy_w[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
    end else if (clr_i) begin
      h_q <= '0;
    end else if (step_i) begin
      h_q.c2_p  <= cy_w[1];
      h_q.c3_p  <= cy_w[2];
      h_q.c3_pp <= h_q.c3_p;
    end
  end

  // c1 + (1-z^-1)c2 + (1-z^-1)^2 c3
  always_comb begin
    raw = ofs_t'(cy_w[0])
        + ofs_t'(cy_w[1]) - ofs_t'(h_q.c2_p)
        + ofs_t'(cy_w[2]) - ofs_t'({h_q.c3_p, 1'b0}) + ofs_t'(h_q.c3_pp);
    ofs_o = clr_i ? '0 : raw;
  end
endmodule

// File: rtl/frac_n_div_ctr.sv
module frac_n_div_ctr #(
  parameter int unsigned DIV_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] len_i,
  output logic             load_o,
  output logic             wrap_o
);
  logic [DIV_W-1:0] cnt_q;

  // zero only right after reset; one marks the last cycle of a period
  assign load_o = (cnt_q[DIV_W-1:1] == '0);
  assign wrap_o = (cnt_q == DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_o) cnt_q <= len_i;
    else             cnt_q <= cnt_q - DIV_W'(1);
  end
endmodule

// File: rtl/frac_n_div.sv
module frac_n_div
  import frac_n_div_pkg::*;
#(
  parameter int unsigned INT_W = 9,
  parameter int unsigned MOD_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INT_W-1:0] int_i,
  input  logic [MOD_W-1:0] frac_i,
  input  logic [MOD_W-1:0] mod_i,
  output logic             pulse_o,
  output logic [INT_W:0]   div_o
);
  localparam int unsigned DIV_W = INT_W + 1;
  localparam int unsigned SUM_W = DIV_W + 1;

  logic             load;
  logic             wrap;
  logic             frac_zero;
  ofs_t             ofs;
  logic [SUM_W-1:0] sum;
  logic [DIV_W-1:0] nxt_div;
  logic [DIV_W-1:0] div_q;
  logic             pulse_q;

  assign frac_zero = (frac_i == '0);

  frac_n_div_mash #(.W(MOD_W)) u_mash (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(load & ~frac_zero),
    .clr_i (load & frac_zero),
    .frac_i(frac_i),
    .mod_i (mod_i),
    .ofs_o (ofs)
  );

  always_comb begin
    sum     = {2'b00, int_i} + {{(SUM_W-OFS_W){ofs[OFS_W-1]}}, ofs};
    nxt_div = sum[DIV_W-1:0];
  end

  frac_n_div_ctr #(.DIV_W(DIV_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .len_i (nxt_div),
    .load_o(load),
    .wrap_o(wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= wrap;
      if (load) div_q <= nxt_div;
    end
  end

  assign pulse_o = pulse_q;
  assign div_o   = div_q;
endmodule

// File: rtl/frac_n_div_chk.sv
module frac_n_div_chk
  import frac_n_div_pkg::*;
#(
  parameter int unsigned INT_W = 9,
  parameter int unsigned MOD_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [INT_W-1:0] int_i,
  input logic [MOD_W-1:0] frac_i,
  input logic             pulse_o,
  input logic [INT_W:0]   div_o
);
  localparam int unsigned DIV_W = INT_W + 1;
  localparam int          LO    = INT_MIN + OFS_MIN;
  localparam int          HI    = (2 ** INT_W) - 1 + OFS_MAX;

  logic [DIV_W-1:0] cyc_q;
  logic [DIV_W-1:0] last_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      last_q <= '0;
      seen_q <= 1'b0;
    end else if (pulse_o) begin
      cyc_q  <= DIV_W'(1);
      last_q <= div_o;
      seen_q <= 1'b1;
    end else if (cyc_q != '1) begin
      cyc_q  <= cyc_q + DIV_W'(1);
    end
  end

  // R7
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  // R2
  period_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && seen_q) |-> (cyc_q == last_q));

  // R6
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_o && $past(div_o) != '0) |-> $stable(div_o));

  // R3
  int_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && $past(frac_i) == '0) |-> (div_o == {1'b0, $past(int_i)}));

  // R4
  ofs_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> ((int'(div_o) >= int'($past(int_i)) + OFS_MIN) &&
                 (int'(div_o) <= int'($past(int_i)) + OFS_MAX)));

  // R8
  div_span_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_o != '0) |-> (int'(div_o) >= LO && int'(div_o) <= HI));
endmodule

bind frac_n_div frac_n_div_chk #(.INT_W(INT_W), .MOD_W(MOD_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .int_i  (int_i),
  .frac_i (frac_i),
  .pulse_o(pulse_o),
  .div_o  (div_o)
);

// File: tb/frac_n_div_tb.sv
module frac_n_div_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] int_v = 9'd40;
  logic [11:0] frac_v = '0;
  logic [11:0] mod_v = 12'd5;
  logic       pulse;
  logic [9:0] div;

  int total = 0;
  int bad = 0;
  int since = 0;
  int prev_d = 0;
  bit prev_ok = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  frac_n_div u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .int_i  (int_v),
    .frac_i (frac_v),
    .mod_i  (mod_v),
    .pulse_o(pulse),
    .div_o  (div)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    since++;
  endtask

  // waits for the next pulse; checks R2 and R7 on every period
  task automatic next_period(output int n, output int d);
    do tick(); while (!pulse);
    n = since;
    d = int'(div);
    since = 0;
    chk(n > 1, "R7 pulse width", n, 2);
    if (prev_ok) chk(n == prev_d, "R2 period length", n, prev_d);
    prev_d = d;
    prev_ok = 1'b1;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(pulse == 1'b0, "R1 pulse in reset", int'(pulse), 0);
      chk(div == '0, "R1 div in reset", int'(div), 0);
    end
    rst_n = 1'b1;
    since = 0;
  endtask

  task automatic t_integer(input int iv);
    int n, d;
    frac_v = '0;
    int_v = 9'(iv);
    next_period(n, d);
    next_period(n, d);
    for (int i = 0; i < 5; i++) begin
      next_period(n, d);
      chk(d == iv, "R3 integer div", d, iv);
      chk(n == iv, "R3 integer period", n, iv);
    end
  endtask

  task automatic t_fraction(input int iv, input int fv, input int mv,
                            input int cnt, input bit exact, input string tag);
    int n, d;
    int sum = 0;
    int lo = 1000;
    int hi = 0;
    frac_v = '0;
    next_period(n, d);
    next_period(n, d);
    int_v = 9'(iv);
    mod_v = 12'(mv);
    frac_v = 12'(fv);
    for (int i = 0; i < 4; i++) next_period(n, d);
    for (int i = 0; i < cnt; i++) begin
      next_period(n, d);
      sum += n;
      if (d < lo) lo = d;
      if (d > hi) hi = d;
    end
    chk(lo >= iv - 3, {tag, " R4 low bound"}, lo, iv - 3);
    chk(hi <= iv + 4, {tag, " R4 high bound"}, hi, iv + 4);
    if (exact)
      chk(sum == 6 * (iv * mv + fv), {tag, " R5 exact total"}, sum, 6 * (iv * mv + fv));
  endtask

  task automatic t_midchange();
    int n, d;
    frac_v = '0;
    int_v = 9'd40;
    next_period(n, d);
    next_period(n, d);
    for (int i = 0; i < 10; i++) tick();
    int_v = 9'd52;
    frac_v = 12'd1;
    mod_v = 12'd7;
    chk(div == 10'd40, "R6 div held mid period", int'(div), 40);
    frac_v = '0;
    next_period(n, d);
    chk(n == 40, "R6 running period kept", n, 40);
    chk(d == 52, "R6 new value next period", d, 52);
    next_period(n, d);
    chk(n == 52, "R6 new period length", n, 52);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_integer(40);
    t_integer(31);
    t_midchange();
    t_fraction(31, 1, 2, 12, 1'b1, "mod2");
    t_fraction(40, 2, 5, 30, 1'b1, "mod5");
    t_fraction(31, 12, 13, 78, 1'b1, "R8 int31");
    t_fraction(511, 1, 3, 18, 1'b1, "R8 int511");
    t_fraction(100, 4094, 4095, 300, 1'b0, "mod4095");
    t_integer(511);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule